// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block makes the claim decision for memory transactions in a two-port bus bridge. Traffic that starts on the primary side and moves toward the secondary side is downstream. Traffic that starts on the secondary side and moves toward the primary side is upstream.

The block holds two address windows, each with a 1 MB granularity:
- a 32-bit non-prefetchable window;
- a prefetchable window whose base and limit extend to 64 bits through two upper-word registers.

For downstream traffic the windows claim the addresses they cover. For upstream traffic the sense is inverted: an address is forwarded only when it lies outside both windows. A command word holds a memory-enable bit and a master-enable bit. An external video-range input overrides the window result. The decision and a prefetch-allowed flag are combinational in the transaction inputs and the registered configuration.

Configuration is written through a single-cycle register port. The select input also drives a readback mux. Transaction inputs carry no valid/ready pair. The decode has no state and takes no cycles, so there is no back-pressure: the caller samples the result in the same cycle it presents an address. A configuration write is captured on the clock edge and steers decisions from the following cycle on.

Top module: `bwd_decoder`

## Requirements
- R1: After reset, each window's base field and limit field are 0, so each window covers 0000_0000h to 000F_FFFFh. The two upper-word registers are 0, and memory enable and master enable are 0, so no transaction is forwarded.
- R2: The value of `cfg_sel` selects what `cfg_rdata` returns:

  | `cfg_sel` | Register | `cfg_rdata` |
  |---|---|---|
  | 0 | non-prefetchable base | {16'h0, field, 4'h0} |
  | 1 | non-prefetchable limit | {16'h0, field, 4'h0} |
  | 2 | prefetchable base | {16'h0, field, 4'h1} |
  | 3 | prefetchable limit | {16'h0, field, 4'h1} |
  | 4 | prefetchable upper base | the full 32 bits |
  | 5 | prefetchable upper limit | the full 32 bits |
  | 6 | command word | bit0 memory enable, bit1 master enable |
  | 7 | none | 0 |

  Each field is 12 bits. A 16-bit register takes its field from `cfg_wdata[15:4]`.
- R3: A write with `cfg_we` high takes effect at the next rising clock edge. A decode in the same cycle as the write still uses the old configuration.
- R4: The non-prefetchable window matches a single address cycle whose address A satisfies {base,00000h} <= A <= {limit,FFFFFh}.
- R5: The prefetchable window compares a 64-bit address against {upper base, base, 00000h} and {upper limit, limit, FFFFFh}. A single address cycle uses upper word 0 and ignores `txn_addr_hi`. A dual address cycle uses `txn_addr_hi`.
- R6: A primary-side transaction (`txn_from_sec`=0) is forwarded only when memory enable is 1. It is forwarded if it lies in either window or `vga_hit` is 1.
- R7: A secondary-side transaction is forwarded only when master enable is 1, it lies outside both windows, and `vga_hit` is 0.
- R8: A window whose full base exceeds its full limit matches nothing. For the prefetchable window, equal upper words with the lower base above the lower limit disables it.
- R9: With upper base 0 and upper limit nonzero, the following apply. A primary-side single address cycle at or above the base is forwarded. A dual address cycle at or below the 64-bit limit is forwarded downstream, and one above the limit is forwarded upstream.
- R10: `txn_cmd` encodes 0 read, 1 read-line, 2 read-multiple and 3 write. `prefetch_ok` is 1 only for a forwarded read, and only when one of these holds:
  - the command is read-line or read-multiple;
  - it is a downstream plain read that hits the prefetchable window and not the non-prefetchable window.
- R11: A dual address cycle never matches the non-prefetchable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for write and readback |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| txn_addr_lo | input | 32 | Address bits [31:0] |
| txn_addr_hi | input | 32 | Address bits [63:32], dual address cycles only |
| txn_dac | input | 1 | 1 for a dual address cycle |
| txn_from_sec | input | 1 | 1 when the transaction starts on the secondary side |
| txn_cmd | input | 2 | Memory command code |
| vga_hit | input | 1 | External video-range override |
| fwd | output | 1 | Claim and forward the transaction |
| prefetch_ok | output | 1 | Reads beyond the requested data are allowed |

## Verification
Two functions can act in the same cycle: a configuration write and the decode of a live transaction.

The bench provokes this by presenting an address inside an active window and, in the same cycle, writing a command word that clears memory enable. It judges `fwd` twice:
- before the edge, `fwd` must show the claim;
- one cycle later, `fwd` must show the refusal.

The window sweeps also raise the video override while addresses sit inside, outside and on the edges of both windows. This checks that the override and the window result combine as required in one cycle.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W  = 32;
  localparam int GRAN_W  = 20;
  localparam int FIELD_W = ADDR_W - GRAN_W;
  localparam int WIDE_W  = 2 * ADDR_W;

  typedef enum logic [1:0] {
    CMD_RD      = 2'd0,
    CMD_RD_LINE = 2'd1,
    CMD_RD_MULT = 2'd2,
    CMD_WR      = 2'd3
  } mem_cmd_e;

  typedef enum logic [2:0] {
    SEL_NP_BASE    = 3'd0,
    SEL_NP_LIM     = 3'd1,
    SEL_PF_BASE    = 3'd2,
    SEL_PF_LIM     = 3'd3,
    SEL_PF_BASE_HI = 3'd4,
    SEL_PF_LIM_HI  = 3'd5,
    SEL_CTRL       = 3'd6,
    SEL_NONE       = 3'd7
  } cfg_sel_e;

  typedef struct packed {
    logic [FIELD_W-1:0] np_base;
    logic [FIELD_W-1:0] np_lim;
    logic [FIELD_W-1:0] pf_base;
    logic [FIELD_W-1:0] pf_lim;
    logic [ADDR_W-1:0]  pf_base_hi;
    logic [ADDR_W-1:0]  pf_lim_hi;
    logic               mem_en;
    logic               mst_en;
  } cfg_state_t;
endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output cfg_state_t        cfg
);
  localparam int LOW_W = 4;

  cfg_state_t st_q;
  cfg_sel_e   sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_NP_BASE:    st_q.np_base    <= cfg_wdata[LOW_W +: FIELD_W];
        SEL_NP_LIM:     st_q.np_lim     <= cfg_wdata[LOW_W +: FIELD_W];
        SEL_PF_BASE:    st_q.pf_base    <= cfg_wdata[LOW_W +: FIELD_W];
        SEL_PF_LIM:     st_q.pf_lim     <= cfg_wdata[LOW_W +: FIELD_W];
        SEL_PF_BASE_HI: st_q.pf_base_hi <= cfg_wdata;
        SEL_PF_LIM_HI:  st_q.pf_lim_hi  <= cfg_wdata;
        SEL_CTRL: begin
          st_q.mem_en <= cfg_wdata[0];
          st_q.mst_en <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_NP_BASE:    cfg_rdata = ADDR_W'({st_q.np_base, 4'h0});
      SEL_NP_LIM:     cfg_rdata = ADDR_W'({st_q.np_lim,  4'h0});
      SEL_PF_BASE:    cfg_rdata = ADDR_W'({st_q.pf_base, 4'h1});
      SEL_PF_LIM:     cfg_rdata = ADDR_W'({st_q.pf_lim,  4'h1});
      SEL_PF_BASE_HI: cfg_rdata = st_q.pf_base_hi;
      SEL_PF_LIM_HI:  cfg_rdata = st_q.pf_lim_hi;
      SEL_CTRL:       cfg_rdata = ADDR_W'({st_q.mst_en, st_q.mem_en});
      default:        cfg_rdata = '0;
    endcase
  end

  assign cfg = st_q;
endmodule

// File: rtl/bwd_range_cmp.sv
module bwd_range_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bwd_decoder.sv
module bwd_decoder
  import bwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] txn_addr_lo,
  input  logic [31:0] txn_addr_hi,
  input  logic        txn_dac,
  input  logic        txn_from_sec,
  input  logic [1:0]  txn_cmd,
  input  logic        vga_hit,
  output logic        fwd,
  output logic        prefetch_ok
);
  localparam logic [GRAN_W-1:0] GRAN_ZERO = '0;
  localparam logic [GRAN_W-1:0] GRAN_ONES = '1;

  cfg_state_t cfg;
  logic       mem_en, mst_en;
  logic       np_raw, np_hit, pf_hit, in_window;
  logic       go_down, go_up, is_read, burst_cmd;
  mem_cmd_e   cmd;

  logic [ADDR_W-1:0] np_lo, np_hi;
  logic [WIDE_W-1:0] pf_lo, pf_hi, addr_wide;

  bwd_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg       (cfg)
  );

  assign mem_en = cfg.mem_en;
  assign mst_en = cfg.mst_en;

  assign np_lo     = {cfg.np_base, GRAN_ZERO};
  assign np_hi     = {cfg.np_lim,  GRAN_ONES};
  assign pf_lo     = {cfg.pf_base_hi, cfg.pf_base, GRAN_ZERO};
  assign pf_hi     = {cfg.pf_lim_hi,  cfg.pf_lim,  GRAN_ONES};
  assign addr_wide = {(txn_dac ? txn_addr_hi : {ADDR_W{1'b0}}), txn_addr_lo};

  bwd_range_cmp #(.W(ADDR_W)) u_np_cmp (
    .addr (txn_addr_lo),
    .lo   (np_lo),
    .hi   (np_hi),
    .hit  (np_raw)
  );

  bwd_range_cmp #(.W(WIDE_W)) u_pf_cmp (
    .addr (addr_wide),
    .lo   (pf_lo),
    .hi   (pf_hi),
    .hit  (pf_hit)
  );

  // the 32-bit window cannot see a dual address cycle
  assign np_hit    = np_raw && !txn_dac;
  assign in_window = np_hit || pf_hit;

  assign go_down = !txn_from_sec && mem_en && (in_window || vga_hit);
  assign go_up   =  txn_from_sec && mst_en && !in_window && !vga_hit;
  assign fwd     = go_down || go_up;

  assign cmd       = mem_cmd_e'(txn_cmd);
  assign is_read   = (cmd != CMD_WR);
  assign burst_cmd = (cmd == CMD_RD_LINE) || (cmd == CMD_RD_MULT);

  // overlap of both windows is treated as side-effect space
  assign prefetch_ok = fwd && is_read &&
                       (burst_cmd || (go_down && pf_hit && !np_hit));
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        txn_dac,
  input logic        txn_from_sec,
  input logic [1:0]  txn_cmd,
  input logic        vga_hit,
  input logic        fwd,
  input logic        prefetch_ok,
  input logic        np_hit,
  input logic        pf_hit,
  input logic        mem_en,
  input logic        mst_en
);
  assert_dn_needs_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && !txn_from_sec) |-> mem_en);

  assert_video_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_hit && !txn_from_sec && mem_en) |-> fwd);

  assert_up_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && txn_from_sec) |-> (mst_en && !vga_hit && !np_hit && !pf_hit));

  assert_dac_no_np_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_dac |-> !np_hit);

  assert_pf_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_ok |-> (fwd && txn_cmd != 2'd3));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd6) |=>
      (mem_en == $past(cfg_wdata[0]) && mst_en == $past(cfg_wdata[1])));

  assert_np_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 3'd0 || cfg_sel == 3'd1) |-> (cfg_rdata[3:0] == 4'h0));

  assert_pf_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 3'd2 || cfg_sel == 3'd3) |-> (cfg_rdata[3:0] == 4'h1));
endmodule

bind bwd_decoder bwd_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .txn_dac      (txn_dac),
  .txn_from_sec (txn_from_sec),
  .txn_cmd      (txn_cmd),
  .vga_hit      (vga_hit),
  .fwd          (fwd),
  .prefetch_ok  (prefetch_ok),
  .np_hit       (np_hit),
  .pf_hit       (pf_hit),
  .mem_en       (mem_en),
  .mst_en       (mst_en)
);

// File: tb/bwd_decoder_tb.sv
module bwd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd7;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] txn_addr_lo = '0;
  logic [31:0] txn_addr_hi = '0;
  logic        txn_dac = 1'b0;
  logic        txn_from_sec = 1'b0;
  logic [1:0]  txn_cmd = 2'd0;
  logic        vga_hit = 1'b0;
  logic        fwd, prefetch_ok;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [11:0] m_nb, m_nl, m_pb, m_pl;
  logic [31:0] m_pbh, m_plh;
  logic        m_mem, m_mst;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .txn_addr_lo(txn_addr_lo), .txn_addr_hi(txn_addr_hi), .txn_dac(txn_dac),
    .txn_from_sec(txn_from_sec), .txn_cmd(txn_cmd), .vga_hit(vga_hit),
    .fwd(fwd), .prefetch_ok(prefetch_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_sel = 3'd7;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    cfg_sel = sel; #1;
    check(tag, cfg_rdata, exp);
    cfg_sel = 3'd7;
  endtask

  task automatic setup(input logic [11:0] nb, nl, pb, pl,
                       input logic [31:0] pbh, plh, input logic mem, mst);
    m_nb = nb; m_nl = nl; m_pb = pb; m_pl = pl;
    m_pbh = pbh; m_plh = plh; m_mem = mem; m_mst = mst;
    wr(3'd0, {16'h0, nb, 4'h0});
    wr(3'd1, {16'h0, nl, 4'h0});
    wr(3'd2, {16'h0, pb, 4'h0});
    wr(3'd3, {16'h0, pl, 4'h0});
    wr(3'd4, pbh);
    wr(3'd5, plh);
    wr(3'd6, {30'h0, mst, mem});
  endtask

  // expected results from the requirement text
  function automatic logic [1:0] model(input logic [31:0] lo, hi, input logic dac,
                                       sec, input logic [1:0] cmd, input logic vga);
    logic [63:0] a = {dac ? hi : 32'h0, lo};
    logic np = !dac && (lo >= {m_nb, 20'h0}) && (lo <= {m_nl, 20'hFFFFF});
    logic pf = (a >= {m_pbh, m_pb, 20'h0}) && (a <= {m_plh, m_pl, 20'hFFFFF});
    logic dn = !sec && m_mem && (np || pf || vga);
    logic up = sec && m_mst && !np && !pf && !vga;
    logic f = dn || up;
    logic p = f && cmd != 2'd3 && (cmd == 2'd1 || cmd == 2'd2 || (dn && pf && !np));
    return {f, p};
  endfunction

  task automatic sweep(input string tag);
    for (int i = 0; i < 18; i++) begin
      for (int half = 0; half < 2; half++) begin
        for (int hv = 0; hv < 4; hv++) begin
          for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
              for (int v = 0; v < 2; v++) begin
                logic [11:0] blk = (i < 16) ? 12'(i) : ((i == 16) ? 12'hFFE : 12'hFFF);
                logic [1:0] e;
                string t;
                txn_addr_lo  = {blk, (half != 0) ? 20'hFFFFF : 20'h0};
                txn_dac      = (hv != 0);
                txn_addr_hi  = txn_dac ? 32'(hv) : 32'hDEAD_BEEF;
                txn_from_sec = s[0];
                txn_cmd      = c[1:0];
                vga_hit      = v[0];
                #1;
                e = model(txn_addr_lo, txn_addr_hi, txn_dac, txn_from_sec, txn_cmd, vga_hit);
                t = $sformatf("%s/%s%s", tag, s ? "R7" : "R6", txn_dac ? "/R11/R5" : "");
                check(t, {31'h0, fwd}, {31'h0, e[1]});
                check({tag, "/R10"}, {31'h0, prefetch_ok}, {31'h0, e[0]});
              end
            end
          end
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 and R2: reset readback
    rd_check("R1/R2 np base", 3'd0, 32'h0);
    rd_check("R1/R2 np lim",  3'd1, 32'h0);
    rd_check("R1/R2 pf base", 3'd2, 32'h1);
    rd_check("R1/R2 pf lim",  3'd3, 32'h1);
    rd_check("R1 pf base hi", 3'd4, 32'h0);
    rd_check("R1 pf lim hi",  3'd5, 32'h0);
    rd_check("R1 ctrl",       3'd6, 32'h0);
    rd_check("R2 empty sel",  3'd7, 32'h0);
    txn_addr_lo = 32'h0008_0000; #1;
    check("R1 no fwd at reset", {31'h0, fwd}, 32'h0);

    // R2: field placement and fixed low nibble
    wr(3'd0, 32'hFFFF_ABCF);
    rd_check("R2 np base field", 3'd0, 32'h0000_ABC0);
    wr(3'd3, 32'h0000_5670);
    rd_check("R2 pf lim field", 3'd3, 32'h0000_5671);
    wr(3'd5, 32'h1234_5678);
    rd_check("R2 upper full", 3'd5, 32'h1234_5678);

    // R1: reset defaults, enables on
    setup(12'h000, 12'h000, 12'h000, 12'h000, 32'h0, 32'h0, 1'b1, 1'b1);
    sweep("R1 default");
    // R4: separate windows below 4 GB
    setup(12'h004, 12'h007, 12'h00A, 12'h00C, 32'h0, 32'h0, 1'b1, 1'b1);
    sweep("R4");
    // R5: prefetchable window above 4 GB
    setup(12'h008, 12'h009, 12'h002, 12'h003, 32'h1, 32'h2, 1'b1, 1'b1);
    sweep("R5");
    // R9: window crosses 4 GB; np disabled
    setup(12'h00F, 12'h00E, 12'h00C, 12'h002, 32'h0, 32'h2, 1'b1, 1'b1);
    sweep("R9");
    // R8: pf disabled with equal uppers, master off
    setup(12'h001, 12'h001, 12'h006, 12'h005, 32'h1, 32'h1, 1'b1, 1'b0);
    sweep("R8");
    // R6: memory enable off
    setup(12'h004, 12'h007, 12'h00A, 12'h00C, 32'h0, 32'h0, 1'b0, 1'b1);
    sweep("R6 mem off");

    // R3: command write concurrent with a claim
    setup(12'h004, 12'h007, 12'h00A, 12'h00C, 32'h0, 32'h0, 1'b1, 1'b1);
    @(negedge clk);
    txn_addr_lo = 32'h0050_0000; txn_dac = 1'b0; txn_addr_hi = '0;
    txn_from_sec = 1'b0; txn_cmd = 2'd0; vga_hit = 1'b0;
    cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'h2;
    #1;
    check("R3 old config same cycle", {31'h0, fwd}, 32'h1);
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_sel = 3'd7;
    check("R3 new config next cycle", {31'h0, fwd}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule